// File: doc/BRIEF.md
# DDR Auto-Refresh Scheduler with Postponement

This block decides when a DDR SDRAM controller must issue auto-refresh commands. A free-running interval timer marks each average refresh period (7.8 µs, i.e. a 64 ms retention window spread across 8192 refreshes). Each expiry adds one owed refresh to a debt counter. The main command scheduler sees a refresh request whenever debt is owed. It may defer that request while it has other traffic. When the debt reaches the postponement ceiling (eight, which keeps the gap between two refreshes under 70.3 µs), an urgent flag tells the scheduler to stop deferring.

When the scheduler issues a refresh, it pulses the acknowledge while the request is high. Bank precharge is the scheduler's job and must already be done at that point. The block then lowers the request and raises a hold output for the full refresh command period. During the hold, clock enable must stay high and no other command may go out.

A simple power sequencer lets the controller place the device in self-refresh once no debt is owed. On exit, it withholds permission for non-read commands for the short exit delay and for reads for the long exit delay. The sequencer then restarts the interval timer with zero debt. A synchronous reset returns everything to its idle state.

Top module: `ref_sched`

## Requirements
- R1: While and immediately after synchronous reset: debt is 0; `ref_req`, `ref_urgent`, `cke_hold`, `ovf_err` and `sr_active` are 0; `cmd_ok` and `read_ok` are 1.
- R2: In the running state, debt rises by one on every INTERVAL_CYC-th clock edge, counted from reset release or from return to the running state. The first increment lands on exactly the INTERVAL_CYC-th edge.
- R3: `ref_req` is high exactly when the block is running, debt is non-zero and `cke_hold` is low.
- R4: An acknowledge that is sampled while `ref_req` is high lowers debt by one. It also raises `cke_hold`, and `cke_hold` stays high for exactly TRFC_CYC cycles starting the cycle after. An acknowledge sampled while `ref_req` is low has no effect on debt or on `cke_hold`.
- R5: If an accepted acknowledge and an interval expiry fall on the same edge, debt is unchanged.
- R6: `ref_urgent` is high exactly when debt equals MAX_DEBT.
- R7: Debt never exceeds MAX_DEBT. An interval expiry at MAX_DEBT with no accepted acknowledge sets `ovf_err`, which stays set until reset.
- R8: A `sr_req` pulse enters self-refresh only when the block is running, debt is 0 and `cke_hold` is low; otherwise it is ignored. In self-refresh, `sr_active` is 1, `cmd_ok` and `read_ok` are 0, and the interval timer is stopped.
- R9: A `sr_exit` pulse sampled in self-refresh lowers `sr_active`. `cmd_ok` then rises on the XS_NONREAD_CYC-th edge after that sampling edge, and `read_ok` rises on the XS_READ_CYC-th edge. At that second edge the block is running again with debt 0 and a fresh interval.
- R10: Asserting reset in the middle of operation clears debt, the overflow flag, the hold and the power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_ack | input | 1 | Scheduler has issued a refresh this cycle |
| sr_req | input | 1 | Request to enter self-refresh |
| sr_exit | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | At least one refresh is owed and may be issued |
| ref_urgent | output | 1 | Postponement ceiling reached; refresh must not be deferred |
| cke_hold | output | 1 | Refresh period in progress; keep clock enable high, issue nothing |
| debt | output | $clog2(MAX_DEBT+1) | Number of refreshes currently owed |
| ovf_err | output | 1 | Sticky: an interval expired with the debt already at the ceiling |
| sr_active | output | 1 | Device is in self-refresh |
| cmd_ok | output | 1 | Non-read commands are permitted |
| read_ok | output | 1 | Read commands are permitted |

## Verification
The bench targets the case where an acknowledge and an interval expiry share one edge. A design that lets either update win would leave debt one too high or one too low. It sends an acknowledge during the hold window, which a careless design would count as a second refresh and so restart the hold. It drives debt up to the ceiling and one interval past it. A design that wrapped the counter, or failed to latch the overflow, would show debt 0 or a clear error flag. Finally, it times the self-refresh exit edge by edge: an off-by-one there would grant reads too early, and an interval timer left running through self-refresh would bring back stale debt.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SELF = 2'd1,
    ST_WAKE = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL_CYC = 1300
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  // R2
  tick_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(run));
endmodule

// File: rtl/ref_debt_ctr.sv
module ref_debt_ctr #(
  parameter int MAX_DEBT = 8,
  parameter int DW = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          tick,
  input  logic          take,
  output logic [DW-1:0] debt,
  output logic          ovf
);
  localparam logic [DW-1:0] CEIL = DW'(MAX_DEBT);

  always_ff @(posedge clk) begin
    if (rst) begin
      debt <= '0;
      ovf  <= 1'b0;
    end else if (clear) begin
      debt <= '0;
    end else begin
      case ({tick, take})
        2'b10: begin
          if (debt == CEIL) ovf <= 1'b1;
          else debt <= debt + 1'b1;
        end
        2'b01: if (debt != '0) debt <= debt - 1'b1;
        default: ;
      endcase
    end
  end

  // R7
  debt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    debt <= CEIL);
  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !take && !clear && debt == CEIL) |=> ovf);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  // R4
  take_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !tick && !clear) |=> (debt == $past(debt) - 1'b1));
endmodule

// File: rtl/ref_hold_timer.sv
module ref_hold_timer #(
  parameter int TRFC_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic hold
);
  localparam int HW = $clog2(TRFC_CYC + 1);

  logic [HW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) bcnt <= '0;
    else if (start) bcnt <= HW'(TRFC_CYC);
    else if (bcnt != '0) bcnt <= bcnt - 1'b1;
  end

  assign hold = (bcnt != '0);

  // R4
  hold_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> hold);
endmodule

// File: rtl/ref_pwr_seq.sv
module ref_pwr_seq
  import ref_sched_pkg::*;
#(
  parameter int XS_NONREAD_CYC = 21,
  parameter int XS_READ_CYC    = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sr_go,
  input  logic       sr_leave,
  output pwr_state_e state,
  output logic       wake_cmd_ok
);
  localparam int XW = $clog2(XS_READ_CYC + 1);
  localparam logic [XW-1:0] NR_LIM = XW'(XS_NONREAD_CYC);
  localparam logic [XW-1:0] RD_LAST = XW'(XS_READ_CYC - 1);

  logic [XW-1:0] xcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RUN;
      xcnt  <= '0;
    end else begin
      case (state)
        ST_RUN:  if (sr_go) state <= ST_SELF;
        ST_SELF: if (sr_leave) begin
          state <= ST_WAKE;
          xcnt  <= '0;
        end
        ST_WAKE: begin
          if (xcnt == RD_LAST) state <= ST_RUN;
          else xcnt <= xcnt + 1'b1;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign wake_cmd_ok = (state == ST_WAKE) && (xcnt >= NR_LIM);

  // R9
  no_direct_run_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SELF) |=> (state != ST_RUN));
  // R8
  self_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SELF && !sr_leave) |=> (state == ST_SELF));
endmodule

// File: rtl/ref_sched.sv
module ref_sched
  import ref_sched_pkg::*;
#(
  parameter int INTERVAL_CYC   = 1300,
  parameter int TRFC_CYC       = 20,
  parameter int MAX_DEBT       = 8,
  parameter int XS_NONREAD_CYC = 21,
  parameter int XS_READ_CYC    = 200
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ref_ack,
  input  logic                           sr_req,
  input  logic                           sr_exit,
  output logic                           ref_req,
  output logic                           ref_urgent,
  output logic                           cke_hold,
  output logic [$clog2(MAX_DEBT+1)-1:0]  debt,
  output logic                           ovf_err,
  output logic                           sr_active,
  output logic                           cmd_ok,
  output logic                           read_ok
);
  localparam int DW = $clog2(MAX_DEBT + 1);
  localparam logic [DW-1:0] CEIL = DW'(MAX_DEBT);

  pwr_state_e state;
  logic run, tick, take, sr_go, wake_cmd_ok;

  assign run   = (state == ST_RUN);
  assign take  = ref_ack && ref_req;
  assign sr_go = sr_req && run && (debt == '0) && !cke_hold;

  ref_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  ref_debt_ctr #(.MAX_DEBT(MAX_DEBT), .DW(DW)) u_debt (
    .clk(clk), .rst(rst), .clear(!run), .tick(tick), .take(take),
    .debt(debt), .ovf(ovf_err)
  );

  ref_hold_timer #(.TRFC_CYC(TRFC_CYC)) u_hold (
    .clk(clk), .rst(rst), .start(take), .hold(cke_hold)
  );

  ref_pwr_seq #(.XS_NONREAD_CYC(XS_NONREAD_CYC), .XS_READ_CYC(XS_READ_CYC)) u_pwr (
    .clk(clk), .rst(rst), .sr_go(sr_go), .sr_leave(sr_exit),
    .state(state), .wake_cmd_ok(wake_cmd_ok)
  );

  assign ref_req    = run && (debt != '0) && !cke_hold;
  assign ref_urgent = (debt == CEIL);
  assign sr_active  = (state == ST_SELF);
  assign cmd_ok     = run ? !cke_hold : wake_cmd_ok;
  assign read_ok    = run && !cke_hold;

  // R8
  sr_entry_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_active) |-> ($past(debt) == '0));
  // R9
  read_implies_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    read_ok |-> cmd_ok);
  // R6
  urgent_served_chk: assert property (@(posedge clk) disable iff (rst)
    ref_urgent |-> (ref_req || cke_hold));
  // R4
  hold_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_ack && ref_req) |=> (cke_hold && !ref_req));
endmodule

// File: tb/ref_sched_tb_top.sv
module ref_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL = 20;
  localparam int TRFC = 4;
  localparam int MAXD = 8;
  localparam int XSNR = 3;
  localparam int XSRD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_ack = 1'b0, sr_req = 1'b0, sr_exit = 1'b0;
  logic ref_req, ref_urgent, cke_hold, ovf_err, sr_active, cmd_ok, read_ok;
  logic [3:0] debt;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_sched #(
    .INTERVAL_CYC(INTERVAL), .TRFC_CYC(TRFC), .MAX_DEBT(MAXD),
    .XS_NONREAD_CYC(XSNR), .XS_READ_CYC(XSRD)
  ) dut_i (
    .clk(clk), .rst(rst), .ref_ack(ref_ack), .sr_req(sr_req), .sr_exit(sr_exit),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .cke_hold(cke_hold), .debt(debt),
    .ovf_err(ovf_err), .sr_active(sr_active), .cmd_ok(cmd_ok), .read_ok(read_ok)
  );

  // {ack, wait, debt, req, urgent, hold, ovf}
  localparam int NV = 17;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'd19,  4'd0, 4'b0000},  // just before first interval
    {1'b0, 8'd1,   4'd1, 4'b1000},  // first interval expiry
    {1'b1, 8'd1,   4'd0, 4'b0010},  // accepted ack
    {1'b0, 8'd3,   4'd0, 4'b0010},  // last hold cycle
    {1'b0, 8'd1,   4'd0, 4'b0000},  // hold over
    {1'b0, 8'd15,  4'd1, 4'b1000},
    {1'b0, 8'd20,  4'd2, 4'b1000},  // postponed: two owed
    {1'b1, 8'd1,   4'd1, 4'b0010},
    {1'b1, 8'd1,   4'd1, 4'b0010},  // ack during hold ignored
    {1'b0, 8'd3,   4'd1, 4'b1000},
    {1'b0, 8'd14,  4'd1, 4'b1000},
    {1'b1, 8'd1,   4'd1, 4'b0010},  // R5 ack and expiry on one edge
    {1'b0, 8'd4,   4'd1, 4'b1000},
    {1'b0, 8'd135, 4'd7, 4'b1000},
    {1'b0, 8'd1,   4'd8, 4'b1100},  // ceiling reached
    {1'b0, 8'd20,  4'd8, 4'b1101},  // expiry at ceiling
    {1'b1, 8'd1,   4'd7, 4'b0011}   // overflow stays sticky
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    edges(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 debt", debt, 0);
    chk("R1 req", ref_req, 0);
    chk("R1 urgent", ref_urgent, 0);
    chk("R1 hold", cke_hold, 0);
    chk("R1 ovf", ovf_err, 0);
    chk("R1 sr_active", sr_active, 0);
    chk("R1 cmd_ok", cmd_ok, 1);
    chk("R1 read_ok", read_ok, 1);

    for (int v = 0; v < NV; v++) begin
      ref_ack = VEC[v][16];
      edges(1);
      ref_ack = 1'b0;
      edges(int'(VEC[v][15:8]) - 1);
      chk("R2 debt", debt, int'(VEC[v][7:4]));
      chk("R3 req", ref_req, VEC[v][3]);
      chk("R6 urgent", ref_urgent, VEC[v][2]);
      chk("R4 hold", cke_hold, VEC[v][1]);
      chk("R7 ovf", ovf_err, VEC[v][0]);
    end

    // R8: self-refresh request refused with debt owed and hold active
    sr_req = 1'b1;
    edges(1);
    sr_req = 1'b0;
    chk("R8 refused", sr_active, 0);

    // R10: reset mid-operation
    rst = 1'b1;
    edges(2);
    rst = 1'b0;
    chk("R10 debt", debt, 0);
    chk("R10 ovf", ovf_err, 0);
    chk("R10 hold", cke_hold, 0);
    chk("R10 cmd_ok", cmd_ok, 1);

    // R8: accepted entry with zero debt
    sr_req = 1'b1;
    edges(1);
    sr_req = 1'b0;
    chk("R8 sr_active", sr_active, 1);
    chk("R8 cmd_ok", cmd_ok, 0);
    chk("R8 read_ok", read_ok, 0);
    edges(40);
    chk("R8 timer stopped", debt, 0);
    chk("R8 no req", ref_req, 0);

    // R9: exit sequencing
    sr_exit = 1'b1;
    edges(1);
    sr_exit = 1'b0;
    chk("R9 sr_active", sr_active, 0);
    edges(XSNR - 1);
    chk("R9 cmd_ok early", cmd_ok, 0);
    edges(1);
    chk("R9 cmd_ok", cmd_ok, 1);
    chk("R9 read_ok early", read_ok, 0);
    edges(XSRD - XSNR - 1);
    chk("R9 read_ok early2", read_ok, 0);
    edges(1);
    chk("R9 read_ok", read_ok, 1);
    chk("R9 debt", debt, 0);
    edges(INTERVAL - 1);
    chk("R9 fresh interval", debt, 0);
    edges(1);
    chk("R9 first tick", debt, 1);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule